// File: doc/BRIEF.md
# Logical Device Configuration Bank with I/O Conflict Probe

This block holds the configuration state of one logical device on a plug-and-play expansion card. The card's configuration sequencer presents it with an 8-bit register index and write data. The bank stores an enable bit that puts the device on the bus, a conflict-probe control, eight 16-bit I/O base addresses, two interrupt entries and two DMA-channel entries. Any indexed register can be read back combinationally.

The block also watches host I/O cycles. When the device is inactive and the conflict probe is armed, a host read that lands inside one of the device's assigned I/O windows gets a fixed byte. That byte is 0x55 or 0xAA, as the probe control selects, and it is driven with an output enable. Firmware uses this to find address clashes before it turns the device on. Arming the probe and activating the device exclude each other.

Top module: `ldev_cfg_bank`

## Requirements
- R1: After rst_n is released, index 0x30 and 0x31 read 0x00, all I/O base bytes and interrupt bytes read 0x00, both DMA entries (0x74, 0x75) read 0x04 (no channel), and io_oe is low.
- R2: A register changes only on a rising clock edge where both cfg_en and cfg_wr are high. A write strobe with cfg_en low leaves every register unchanged.
- R3: Index 0x30 stores write bit 0 as the device-active flag. Reads of 0x30 return that flag in bit 0, with bits 7:1 zero.
- R4: Index 0x31 stores bit 1 as the probe enable and bit 0 as the pattern select. Reads of 0x31 return the probe enable in bit 1 and the pattern select in bit 0, with bits 7:2 zero.
- R5: The device-active flag and the probe enable are never both set. Writing 1 to 0x30 bit 0 clears the probe enable on the same edge. A write of 0x31 while the device is active stores the probe enable as 0.
- R6: I/O window n (n = 0..7) has its base high byte at index 0x60+2n and its low byte at 0x61+2n. Both bytes are read/write over all 8 bits.
- R7: Interrupt entry m (m = 0..1) keeps a 4-bit level at 0x70+2m, which reads with bits 7:4 zero. It keeps a control byte at 0x71+2m: bit 1 is polarity (1 = high) and bit 0 is type (1 = level). That byte reads with bits 7:2 zero.
- R8: DMA entry k (k = 0..1) at index 0x74+k keeps bits 2:0 as a channel number and reads with bits 7:3 zero.
- R9: io_oe is high, in the same cycle and combinationally, exactly when all of the following hold: io_rd is high, io_wr is low, the probe is enabled, the device is inactive, and io_addr lies in [base, base+8) of some window whose base is nonzero. io_rdata is then 0x55 if the pattern select is 1 and 0xAA if it is 0.
- R10: While io_wr is high, io_oe stays low whatever the address.
- R11: A clock edge with ldev_reset high returns every register to its R1 value, and ldev_reset takes priority over a write on the same edge.
- R12: Indices that are not mapped above (for example 0x20 and 0x76) read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Card is in its configuration state; gates writes |
| cfg_wr | input | 1 | Write strobe for the indexed register |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational readback of the indexed register |
| ldev_reset | input | 1 | Synchronous logical-device reset to defaults |
| io_rd | input | 1 | Host I/O read cycle |
| io_wr | input | 1 | Host I/O write cycle |
| io_addr | input | 16 | Host I/O address |
| io_rdata | output | 8 | Probe reply byte (0 when not driving) |
| io_oe | output | 1 | Output enable for io_rdata |

## Verification
Most corrupted bank state shows up on cfg_rdata as soon as the next index is presented, with no latency, because readback is combinational. A wrong window base or a wrong window span shows on io_oe in the same cycle as a host read at the window edges: base-1, base, base+7 and base+8. If the active flag and the probe enable both end up set, a probe reply appears while the device is active. This is visible at once on io_oe, and the 0x31 readback shows it on the next read.

// File: rtl/ldev_cfg_pkg.sv
package ldev_cfg_pkg;
  localparam logic [7:0] IDX_ACT  = 8'h30;
  localparam logic [7:0] IDX_RCHK = 8'h31;
  localparam logic [7:0] IDX_IOB  = 8'h60;
  localparam logic [7:0] IDX_IRQ  = 8'h70;
  localparam logic [7:0] IDX_DMA  = 8'h74;
  localparam logic [7:0] PAT_ONE  = 8'h55;
  localparam logic [7:0] PAT_ZERO = 8'hAA;
  localparam logic [2:0] DMA_NONE = 3'd4;

  // Window hit: base nonzero and addr-base below span (unsigned, no wrap)
  function automatic logic window_hit(input logic [15:0] addr,
                                      input logic [15:0] base,
                                      input int unsigned span);
    logic [16:0] diff;
    diff = {1'b0, addr} - {1'b0, base};
    return (base != 16'h0000) && (diff < 17'(span));
  endfunction

  function automatic logic [7:0] probe_byte(input logic sel);
    return sel ? PAT_ONE : PAT_ZERO;
  endfunction
endpackage

// File: rtl/ldev_ctrl_regs.sv
module ldev_ctrl_regs
  import ldev_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ok,
  input  logic       ldev_reset,
  input  logic [7:0] idx,
  input  logic [1:0] wbits,
  output logic [7:0] rdata,
  output logic       active,
  output logic       rchk_en,
  output logic       rchk_sel
);
  logic act_q, en_q, sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      en_q  <= 1'b0;
      sel_q <= 1'b0;
    end else if (ldev_reset) begin
      act_q <= 1'b0;
      en_q  <= 1'b0;
      sel_q <= 1'b0;
    end else if (wr_ok && idx == IDX_ACT) begin
      act_q <= wbits[0];
      if (wbits[0]) en_q <= 1'b0;
    end else if (wr_ok && idx == IDX_RCHK) begin
      en_q  <= wbits[1] & ~act_q;
      sel_q <= wbits[0];
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (idx == IDX_ACT)  rdata = {7'b0, act_q};
    if (idx == IDX_RCHK) rdata = {6'b0, en_q, sel_q};
  end

  assign active   = act_q;
  assign rchk_en  = en_q;
  assign rchk_sel = sel_q;
endmodule

// File: rtl/ldev_res_regs.sv
module ldev_res_regs
  import ldev_cfg_pkg::*;
#(
  parameter int NUM_IO  = 8,
  parameter int NUM_IRQ = 2,
  parameter int NUM_DMA = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_ok,
  input  logic                   ldev_reset,
  input  logic [7:0]             idx,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic [NUM_IO-1:0][15:0] io_base
);
  logic [7:0] base_hi [NUM_IO];
  logic [7:0] base_lo [NUM_IO];
  logic [3:0] irq_lvl [NUM_IRQ];
  logic [1:0] irq_ctl [NUM_IRQ];
  logic [2:0] dma_ch  [NUM_DMA];

  for (genvar i = 0; i < NUM_IO; i++) begin : g_iob
    localparam logic [7:0] HI_IDX = IDX_IOB + 8'(2 * i);
    localparam logic [7:0] LO_IDX = IDX_IOB + 8'(2 * i + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_hi[i] <= 8'h00;
        base_lo[i] <= 8'h00;
      end else if (ldev_reset) begin
        base_hi[i] <= 8'h00;
        base_lo[i] <= 8'h00;
      end else if (wr_ok) begin
        if (idx == HI_IDX) base_hi[i] <= wdata;
        if (idx == LO_IDX) base_lo[i] <= wdata;
      end
    end
    assign io_base[i] = {base_hi[i], base_lo[i]};
  end

  for (genvar m = 0; m < NUM_IRQ; m++) begin : g_irq
    localparam logic [7:0] LV_IDX = IDX_IRQ + 8'(2 * m);
    localparam logic [7:0] CT_IDX = IDX_IRQ + 8'(2 * m + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_lvl[m] <= 4'h0;
        irq_ctl[m] <= 2'b00;
      end else if (ldev_reset) begin
        irq_lvl[m] <= 4'h0;
        irq_ctl[m] <= 2'b00;
      end else if (wr_ok) begin
        if (idx == LV_IDX) irq_lvl[m] <= wdata[3:0];
        if (idx == CT_IDX) irq_ctl[m] <= wdata[1:0];
      end
    end
  end

  for (genvar k = 0; k < NUM_DMA; k++) begin : g_dma
    localparam logic [7:0] CH_IDX = IDX_DMA + 8'(k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        dma_ch[k] <= DMA_NONE;
      else if (ldev_reset)               dma_ch[k] <= DMA_NONE;
      else if (wr_ok && idx == CH_IDX)   dma_ch[k] <= wdata[2:0];
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NUM_IO; i++) begin
      if (idx == IDX_IOB + 8'(2 * i))     rdata = base_hi[i];
      if (idx == IDX_IOB + 8'(2 * i + 1)) rdata = base_lo[i];
    end
    for (int m = 0; m < NUM_IRQ; m++) begin
      if (idx == IDX_IRQ + 8'(2 * m))     rdata = {4'h0, irq_lvl[m]};
      if (idx == IDX_IRQ + 8'(2 * m + 1)) rdata = {6'h00, irq_ctl[m]};
    end
    for (int k = 0; k < NUM_DMA; k++) begin
      if (idx == IDX_DMA + 8'(k))         rdata = {5'h00, dma_ch[k]};
    end
  end
endmodule

// File: rtl/ldev_range_match.sv
module ldev_range_match
  import ldev_cfg_pkg::*;
#(
  parameter int NUM_IO = 8,
  parameter int SPAN   = 8
) (
  input  logic [NUM_IO-1:0][15:0] io_base,
  input  logic [15:0]             addr,
  output logic                    hit_any
);
  logic [NUM_IO-1:0] hit;

  for (genvar i = 0; i < NUM_IO; i++) begin : g_win
    assign hit[i] = window_hit(addr, io_base[i], SPAN);
  end

  assign hit_any = |hit;
endmodule

// File: rtl/ldev_cfg_bank.sv
module ldev_cfg_bank
  import ldev_cfg_pkg::*;
#(
  parameter int NUM_IO   = 8,
  parameter int NUM_IRQ  = 2,
  parameter int NUM_DMA  = 2,
  parameter int IO_SPAN  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_en,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_idx,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        ldev_reset,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  output logic [7:0]  io_rdata,
  output logic        io_oe
);
  logic                    wr_ok;
  logic [7:0]              ctrl_rdata, res_rdata;
  logic                    dev_active, rchk_on, rchk_sel;
  logic [NUM_IO-1:0][15:0] io_base;
  logic                    range_hit_any;
  logic                    probe_reply;

  assign wr_ok = cfg_en & cfg_wr;

  ldev_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .ldev_reset(ldev_reset),
    .idx(cfg_idx), .wbits(cfg_wdata[1:0]), .rdata(ctrl_rdata),
    .active(dev_active), .rchk_en(rchk_on), .rchk_sel(rchk_sel)
  );

  ldev_res_regs #(.NUM_IO(NUM_IO), .NUM_IRQ(NUM_IRQ), .NUM_DMA(NUM_DMA)) u_res (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .ldev_reset(ldev_reset),
    .idx(cfg_idx), .wdata(cfg_wdata), .rdata(res_rdata), .io_base(io_base)
  );

  ldev_range_match #(.NUM_IO(NUM_IO), .SPAN(IO_SPAN)) u_match (
    .io_base(io_base), .addr(io_addr), .hit_any(range_hit_any)
  );

  assign cfg_rdata   = ctrl_rdata | res_rdata;
  assign probe_reply = io_rd & ~io_wr & rchk_on & ~dev_active & range_hit_any;
  assign io_oe       = probe_reply;
  assign io_rdata    = probe_reply ? probe_byte(rchk_sel) : 8'h00;
endmodule

// File: rtl/ldev_cfg_chk.sv
module ldev_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_en,
  input logic       ldev_reset,
  input logic       io_wr,
  input logic       io_oe,
  input logic [7:0] io_rdata,
  input logic       act,
  input logic       rc_en,
  input logic       hit
);
  // R10
  wr_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> !io_oe);

  // R9
  active_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> !io_oe);

  // R9
  reply_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> (hit && (io_rdata == 8'h55 || io_rdata == 8'hAA)));

  // R5
  modes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(act && rc_en));

  // R11
  ldev_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ldev_reset |=> (!act && !rc_en));

  // R2
  closed_bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !ldev_reset) |=> ($stable(act) && $stable(rc_en)));
endmodule

bind ldev_cfg_bank ldev_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .ldev_reset(ldev_reset),
  .io_wr(io_wr), .io_oe(io_oe), .io_rdata(io_rdata),
  .act(dev_active), .rc_en(rchk_on), .hit(range_hit_any)
);

// File: tb/tb_ldev_cfg_bank.sv
module tb_ldev_cfg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_wr = 1'b0, ldev_reset = 1'b0;
  logic [7:0]  cfg_idx = 8'h00, cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_rdata;
  logic        io_oe;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ldev_cfg_bank dut (.*);

  // {req, idx, wdata, expected readback}
  localparam logic [27:0] VEC [14] = '{
    {4'd3,  8'h30, 8'hFF, 8'h01},  // R3
    {4'd3,  8'h30, 8'h00, 8'h00},  // R3
    {4'd4,  8'h31, 8'hFF, 8'h03},  // R4
    {4'd4,  8'h31, 8'h00, 8'h00},  // R4
    {4'd6,  8'h60, 8'h12, 8'h12},  // R6
    {4'd6,  8'h61, 8'h34, 8'h34},  // R6
    {4'd6,  8'h6F, 8'hA5, 8'hA5},  // R6
    {4'd7,  8'h70, 8'hFB, 8'h0B},  // R7
    {4'd7,  8'h71, 8'hFF, 8'h03},  // R7
    {4'd7,  8'h73, 8'h01, 8'h01},  // R7
    {4'd8,  8'h74, 8'hFF, 8'h07},  // R8
    {4'd8,  8'h75, 8'h02, 8'h02},  // R8
    {4'd12, 8'h20, 8'hFF, 8'h00},  // R12
    {4'd12, 8'h76, 8'h55, 8'h00}   // R12
  };

  function automatic logic [7:0] expect_probe(input logic sel);
    return sel ? 8'b0101_0101 : 8'b1010_1010;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d, input logic en);
    @(negedge clk);
    cfg_en = en; cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_en = 1'b1;
  endtask

  task automatic cfg_read_chk(input string req, input logic [7:0] idx, input logic [7:0] exp);
    cfg_idx = idx; #1;
    check8(req, cfg_rdata, exp);
  endtask

  task automatic io_chk(input string req, input logic rd, input logic wr,
                        input logic [15:0] a, input logic oe_exp, input logic [7:0] d_exp);
    io_rd = rd; io_wr = wr; io_addr = a; #1;
    check8(req, {7'b0, io_oe}, {7'b0, oe_exp});
    if (oe_exp) check8(req, io_rdata, d_exp);
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cfg_read_chk("R1", 8'h30, 8'h00);
    cfg_read_chk("R1", 8'h31, 8'h00);
    cfg_read_chk("R1", 8'h61, 8'h00);
    cfg_read_chk("R1", 8'h71, 8'h00);
    cfg_read_chk("R1", 8'h74, 8'h04);
    cfg_read_chk("R1", 8'h75, 8'h04);
    check8("R1", {7'b0, io_oe}, 8'h00);

    for (int v = 0; v < 14; v++) begin
      cfg_write(VEC[v][23:16], VEC[v][15:8], 1'b1);
      cfg_read_chk($sformatf("R%0d idx %02h", VEC[v][27:24], VEC[v][23:16]),
                   VEC[v][23:16], VEC[v][7:0]);
    end

    // R9 probe reply at window edges, window 0 base 0x1234
    cfg_write(8'h31, 8'h03, 1'b1);
    io_chk("R9 base",   1, 0, 16'h1234, 1, expect_probe(1'b1));
    io_chk("R9 base+7", 1, 0, 16'h123B, 1, expect_probe(1'b1));
    io_chk("R9 base+8", 1, 0, 16'h123C, 0, 8'h00);
    io_chk("R9 base-1", 1, 0, 16'h1233, 0, 8'h00);
    io_chk("R9 zero base disabled", 1, 0, 16'h0000, 0, 8'h00);
    io_chk("R9 window 7", 1, 0, 16'h00A9, 1, expect_probe(1'b1));
    cfg_write(8'h31, 8'h02, 1'b1);
    io_chk("R9 pattern clear", 1, 0, 16'h1236, 1, expect_probe(1'b0));
    // R10 no drive on writes
    io_chk("R10 write", 0, 1, 16'h1236, 0, 8'h00);
    io_chk("R10 rd+wr", 1, 1, 16'h1236, 0, 8'h00);

    // R5 activation clears probe enable
    cfg_write(8'h31, 8'h03, 1'b1);
    cfg_write(8'h30, 8'h01, 1'b1);
    cfg_read_chk("R5 activate clears probe", 8'h31, 8'h01);
    io_chk("R9 active silent", 1, 0, 16'h1234, 0, 8'h00);
    cfg_write(8'h31, 8'h02, 1'b1);
    cfg_read_chk("R5 probe refused while active", 8'h31, 8'h00);

    // R2 write with cfg_en low ignored
    cfg_write(8'h60, 8'hFF, 1'b0);
    cfg_read_chk("R2 gated write", 8'h60, 8'h12);
    cfg_write(8'h30, 8'h00, 1'b0);
    cfg_read_chk("R2 gated write", 8'h30, 8'h01);

    // R11 logical-device reset beats a simultaneous write
    @(negedge clk);
    ldev_reset = 1'b1; cfg_en = 1'b1; cfg_wr = 1'b1; cfg_idx = 8'h61; cfg_wdata = 8'h77;
    @(negedge clk);
    ldev_reset = 1'b0; cfg_wr = 1'b0;
    cfg_read_chk("R11", 8'h30, 8'h00);
    cfg_read_chk("R11", 8'h60, 8'h00);
    cfg_read_chk("R11", 8'h61, 8'h00);
    cfg_read_chk("R11", 8'h70, 8'h00);
    cfg_read_chk("R11", 8'h74, 8'h04);
    cfg_read_chk("R11", 8'h6F, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule